// File: doc/BRIEF.md
# In-Place ReLU Read-Modify-Write Stage

This stage rectifies a complete feature map that already sits in a dual-port block-RAM-style memory. Every element is replaced by its own rectified value in the same location. One memory port carries a steady stream of reads, one address per clock, rising through a window of `DEPTH` words that starts at `BASE`. The other port writes each rectified word back to the address it was read from. The write follows the read by exactly the memory read latency plus the depth of the stage's own clamp pipeline. Values are signed two's complement fixed point. Negative values become zero and all other values are written back unchanged.

A scheduler starts the stage with a one-cycle `start` pulse. `busy` stays high for the whole run, and during that time the stage alone drives both memory ports. A one-cycle `done` pulse marks completion. It appears in the cycle after the clock edge that takes the final write.

The controller is a four-state machine:
- **ST_IDLE**: waits for `start`.
- **ST_SWEEP**: issues one read per cycle.
- **ST_DRAIN**: reads have stopped and the in-flight words are still being written back.
- **ST_FINISH**: raises `done` for one cycle.

Its transitions are:
- ST_IDLE→ST_SWEEP when `start` is high.
- ST_SWEEP→ST_DRAIN once the last address of the window has been read.
- ST_DRAIN→ST_FINISH when the write to the last address is on the port.
- ST_FINISH→ST_IDLE unconditionally.

Every other case holds the current state.

Top module: `relu_rmw_stage`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done`, `rd_en` and `wr_en` are all 0.
- R2: After a `start` seen in idle, the stage issues exactly `DEPTH` reads on consecutive cycles, at addresses `BASE`, `BASE+1`, … `BASE+DEPTH-1` in rising order, with no gap and no repeat.
- R3: The write-back for the read taken at clock edge k is taken at edge k+`RD_LAT`+`PIPE_D` and targets the same address.
- R4: A word whose most significant (sign) bit is 1 is written back as all zeros. Every other word is written back bit for bit unchanged.
- R5: In one run, each address of the window is written exactly once, and no address outside the window is read or written.
- R6: `done` is high for exactly one cycle, `DEPTH`+`RD_LAT`+`PIPE_D` edges after the edge that captured `start`. `busy` is high from the edge after `start` through the `done` cycle, and low in the cycle after it.
- R7: A `start` pulse while `busy` is high has no effect: the run keeps its timing, and no second sweep follows it.
- R8: Whenever `busy` is low, `rd_en` and `wr_en` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to process the window |
| busy | output | 1 | High while the stage owns the memory |
| done | output | 1 | One-cycle completion pulse |
| rd_en | output | 1 | Read strobe on the read port |
| rd_addr | output | MEM_AW | Read address |
| rd_data | input | DATA_W | Read data, valid `RD_LAT` edges after the read |
| wr_en | output | 1 | Write strobe on the write port |
| wr_addr | output | MEM_AW | Write address |
| wr_data | output | DATA_W | Rectified write data |

## Verification
The bench builds the stage with a 16-bit word and `MEM_AW`=6. The window is 40 words starting at `BASE`=4, which leaves guard words on both sides that must never change. The memory read latency is 3 and the clamp pipeline has 2 stages. With these values a write that lands one cycle early or late ends up at a neighbouring address or carries a neighbour's data, and a latency of 1 would hide exactly that kind of error. Random maps are mixed with directed maps holding the most negative value, zero, the largest positive value and all-negative runs. A stray `start` pulse in the middle of a run exercises the rule that `start` is ignored while busy.

// File: rtl/relu_rmw_pkg.sv
package relu_rmw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SWEEP  = 2'd1,
        ST_DRAIN  = 2'd2,
        ST_FINISH = 2'd3
    } relu_state_e;

endpackage

// File: rtl/relu_rd_sweep.sv
module relu_rd_sweep #(
    parameter int MEM_AW = 8,
    parameter int BASE   = 0,
    parameter int DEPTH  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    output logic [MEM_AW-1:0] addr,
    output logic              last
);
    localparam int CW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(DEPTH - 1);

    logic [CW-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (!go) begin
            idx_q <= '0;
        end else if (idx_q != LAST_IDX) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    assign addr = MEM_AW'(BASE) + MEM_AW'(idx_q);
    assign last = (idx_q == LAST_IDX);

    // R2: while sweeping, the address stays inside the window
    p_read_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (addr >= MEM_AW'(BASE)) && (addr <= MEM_AW'(BASE + DEPTH - 1)));

endmodule

// File: rtl/relu_tag_delay.sv
module relu_tag_delay #(
    parameter int MEM_AW = 8,
    parameter int STAGES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [MEM_AW-1:0] in_addr,
    output logic              out_valid,
    output logic [MEM_AW-1:0] out_addr
);
    logic              v_q [STAGES];
    logic [MEM_AW-1:0] a_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                v_q[i] <= 1'b0;
                a_q[i] <= '0;
            end
        end else begin
            for (int i = STAGES - 1; i > 0; i--) begin
                v_q[i] <= v_q[i-1];
                a_q[i] <= a_q[i-1];
            end
            v_q[0] <= in_valid;
            a_q[0] <= in_addr;
        end
    end

    assign out_valid = v_q[STAGES-1];
    assign out_addr  = a_q[STAGES-1];

endmodule

// File: rtl/relu_clamp_pipe.sv
module relu_clamp_pipe #(
    parameter int DATA_W = 16,
    parameter int MEM_AW = 8,
    parameter int STAGES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [MEM_AW-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [MEM_AW-1:0] out_addr,
    output logic [DATA_W-1:0] out_data
);
    logic              v_q [STAGES];
    logic [MEM_AW-1:0] a_q [STAGES];
    logic [DATA_W-1:0] d_q [STAGES];
    logic [DATA_W-1:0] rect;

    assign rect = in_data[DATA_W-1] ? '0 : in_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                v_q[i] <= 1'b0;
                a_q[i] <= '0;
                d_q[i] <= '0;
            end
        end else begin
            for (int i = STAGES - 1; i > 0; i--) begin
                v_q[i] <= v_q[i-1];
                a_q[i] <= a_q[i-1];
                d_q[i] <= d_q[i-1];
            end
            v_q[0] <= in_valid;
            a_q[0] <= in_addr;
            d_q[0] <= rect;
        end
    end

    assign out_valid = v_q[STAGES-1];
    assign out_addr  = a_q[STAGES-1];
    assign out_data  = d_q[STAGES-1];

    // R4: a written word never carries the sign bit
    p_nonneg_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !out_data[DATA_W-1]);

endmodule

// File: rtl/relu_rmw_stage.sv
module relu_rmw_stage
    import relu_rmw_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int MEM_AW = 8,
    parameter int BASE   = 0,
    parameter int DEPTH  = 64,
    parameter int RD_LAT = 1,
    parameter int PIPE_D = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              rd_en,
    output logic [MEM_AW-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [MEM_AW-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    localparam logic [MEM_AW-1:0] LAST_ADDR = MEM_AW'(BASE + DEPTH - 1);
    localparam int WCW = $clog2(DEPTH + 1);

    relu_state_e state_q, state_d;
    logic        sweep_last;
    logic        tag_valid;
    logic [MEM_AW-1:0] tag_addr;
    logic        final_write;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign final_write = wr_en && (wr_addr == LAST_ADDR);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start)       state_d = ST_SWEEP;
            ST_SWEEP:  if (sweep_last)  state_d = ST_DRAIN;
            ST_DRAIN:  if (final_write) state_d = ST_FINISH;
            ST_FINISH:                  state_d = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        busy  = 1'b0;
        done  = 1'b0;
        rd_en = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_SWEEP:  begin busy = 1'b1; rd_en = 1'b1; end
            ST_DRAIN:  busy = 1'b1;
            ST_FINISH: begin busy = 1'b1; done = 1'b1; end
        endcase
    end

    relu_rd_sweep #(
        .MEM_AW (MEM_AW),
        .BASE   (BASE),
        .DEPTH  (DEPTH)
    ) u_sweep (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (rd_en),
        .addr  (rd_addr),
        .last  (sweep_last)
    );

    relu_tag_delay #(
        .MEM_AW (MEM_AW),
        .STAGES (RD_LAT)
    ) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (rd_en),
        .in_addr   (rd_addr),
        .out_valid (tag_valid),
        .out_addr  (tag_addr)
    );

    relu_clamp_pipe #(
        .DATA_W (DATA_W),
        .MEM_AW (MEM_AW),
        .STAGES (PIPE_D)
    ) u_clamp (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (tag_valid),
        .in_addr   (tag_addr),
        .in_data   (rd_data),
        .out_valid (wr_en),
        .out_addr  (wr_addr),
        .out_data  (wr_data)
    );

    // Write tally used by the completion check
    logic [WCW-1:0] wr_total_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                wr_total_q <= '0;
        else if (state_q == ST_IDLE) wr_total_q <= '0;
        else if (wr_en)            wr_total_q <= wr_total_q + 1'b1;
    end

    // R6: done lasts one cycle
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: no memory traffic unless the stage owns the memory
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rd_en && !wr_en));

    // R2: back-to-back reads advance by one
    p_read_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + 1'b1));

    // R5: back-to-back writes advance by one, so none repeats
    p_write_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + 1'b1));

    // R5: done only once every location has been written
    p_done_all_written_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (wr_total_q == WCW'(DEPTH)));

    // R7: start during a run does not end or restart it
    p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start) |=> busy);

endmodule

// File: tb/relu_rmw_stage_bench.sv
module relu_rmw_stage_bench;
    localparam int DATA_W = 16;
    localparam int MEM_AW = 6;
    localparam int BASE   = 4;
    localparam int DEPTH  = 40;
    localparam int RD_LAT = 3;
    localparam int PIPE_D = 2;
    localparam int MEM_N  = 48;
    localparam int LAT    = RD_LAT + PIPE_D;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic busy, done, rd_en, wr_en;
    logic [MEM_AW-1:0] rd_addr, wr_addr;
    logic [DATA_W-1:0] rd_data, wr_data;

    always #5 clk = ~clk;

    relu_rmw_stage #(
        .DATA_W(DATA_W), .MEM_AW(MEM_AW), .BASE(BASE),
        .DEPTH(DEPTH), .RD_LAT(RD_LAT), .PIPE_D(PIPE_D)
    ) u_relu_rmw_stage (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    // Memory model with RD_LAT-cycle reads, plus a bench load port
    logic [DATA_W-1:0] mem [MEM_N];
    logic [DATA_W-1:0] rq [RD_LAT];
    logic              ld_en = 1'b0;
    int                ld_addr = 0;
    logic [DATA_W-1:0] ld_data = '0;

    always @(posedge clk) begin
        if (ld_en) mem[ld_addr] <= ld_data;
        if (wr_en && int'(wr_addr) < MEM_N) mem[wr_addr] <= wr_data;
        for (int i = RD_LAT - 1; i > 0; i--) rq[i] <= rq[i-1];
        rq[0] <= (rd_en && int'(rd_addr) < MEM_N) ? mem[rd_addr] : '0;
    end
    assign rd_data = rq[RD_LAT-1];

    int checks = 0;
    int bad = 0;
    int edge_no = 0;
    always @(posedge clk) edge_no <= edge_no + 1;

    // Monitor state
    logic              running = 1'b0;
    int                rd_next, n_reads, n_writes, start_edge, done_edge, done_cycles;
    int                order_err, range_err, idle_err, busy_gap;
    int                rd_edge [MEM_N];
    int                wr_edge [MEM_N];
    int                wr_cnt  [MEM_N];
    logic [DATA_W-1:0] golden  [MEM_N];

    always @(negedge clk) begin
        if (running) begin
            if (rd_en) begin
                if (int'(rd_addr) != rd_next) order_err++;
                if (int'(rd_addr) < BASE || int'(rd_addr) >= BASE + DEPTH) range_err++;
                else rd_edge[rd_addr] = edge_no + 1;
                rd_next++;
                n_reads++;
            end
            if (wr_en) begin
                if (int'(wr_addr) < BASE || int'(wr_addr) >= BASE + DEPTH) range_err++;
                else begin
                    wr_cnt[wr_addr]++;
                    wr_edge[wr_addr] = edge_no + 1;
                end
                n_writes++;
            end
            if ((rd_en || wr_en) && !busy) idle_err++;
            if (start && done_edge < 0 && start_edge < 0) start_edge = edge_no + 1;
            if (done) begin
                done_cycles++;
                if (done_edge < 0) done_edge = edge_no;
            end
            if (start_edge >= 0 && done_edge < 0 && edge_no >= start_edge + 1 && !busy)
                busy_gap++;
        end
    end

    always @(posedge clk) begin
        if (edge_no > 150000) begin
            bad++;
            $display("FAIL watchdog: got edge %0d exp < 150000", edge_no);
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    function automatic logic [DATA_W-1:0] relu_ref(input logic [DATA_W-1:0] x);
        return x[DATA_W-1] ? '0 : x;
    endfunction

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d exp %0d", req, got, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] pick(input int pattern, input int i);
        unique case (pattern)
            0: return DATA_W'($urandom);
            1: return (i == 0) ? 16'h8000 : (16'h8000 | DATA_W'($urandom));
            2: return (i == 0) ? 16'h7FFF : (i == 1) ? 16'h0000 : (DATA_W'($urandom) & 16'h7FFF);
            default: begin
                case (i % 4)
                    0: return 16'hFFFF;
                    1: return 16'h0001;
                    2: return 16'h8000;
                    default: return 16'h0000;
                endcase
            end
        endcase
    endfunction

    task automatic load_map(input int pattern);
        for (int a = 0; a < MEM_N; a++) begin
            logic [DATA_W-1:0] v;
            if (a >= BASE && a < BASE + DEPTH) begin
                v = pick(pattern, a - BASE);
                golden[a] = relu_ref(v);
            end else begin
                v = DATA_W'($urandom) | 16'h8000;
                golden[a] = v;
            end
            ld_en = 1'b1; ld_addr = a; ld_data = v;
            @(negedge clk);
        end
        ld_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_case(input int pattern, input bit stray_start);
        int wait_n;
        int writes_ok, align_ok, data_ok, reads_before;
        load_map(pattern);
        for (int a = 0; a < MEM_N; a++) begin
            rd_edge[a] = -1; wr_edge[a] = -1; wr_cnt[a] = 0;
        end
        rd_next = BASE; n_reads = 0; n_writes = 0;
        start_edge = -1; done_edge = -1; done_cycles = 0;
        order_err = 0; range_err = 0; idle_err = 0; busy_gap = 0;
        running = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_n = 0;
        while (done_edge < 0 && wait_n < 500) begin
            @(negedge clk);
            wait_n++;
            if (stray_start && wait_n == 12) start = 1'b1;
            else start = 1'b0;
        end
        start = 1'b0;
        if (done_edge < 0) begin
            bad++;
            $display("FAIL R6 timeout: got no done exp done");
        end
        // cycle after done: busy must be low
        check("R6 busy low after done", int'(busy), 0);
        reads_before = n_reads;
        repeat (8) @(negedge clk);
        running = 1'b0;

        check("R6 done latency", done_edge - start_edge, DEPTH + LAT);
        check("R6 done width", done_cycles, 1);
        check("R6 busy held through run", busy_gap, 0);
        check("R2 read count", n_reads, DEPTH);
        check("R2 read order", order_err, 0);
        check("R5 out-of-window access", range_err, 0);
        check("R8 strobe while idle", idle_err, 0);
        check("R7 no second sweep", n_reads - reads_before, 0);
        writes_ok = 0; align_ok = 0; data_ok = 0;
        for (int a = 0; a < MEM_N; a++) begin
            if (a >= BASE && a < BASE + DEPTH) begin
                if (wr_cnt[a] == 1) writes_ok++;
                if (wr_edge[a] - rd_edge[a] == LAT) align_ok++;
            end
            if (mem[a] == golden[a]) data_ok++;
            else $display("  mismatch at %0d: got %h exp %h", a, mem[a], golden[a]);
        end
        check("R5 written exactly once", writes_ok, DEPTH);
        check("R3 write delay", align_ok, DEPTH);
        check("R4 contents and guards", data_ok, MEM_N);
        check("R5 total writes", n_writes, DEPTH);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int a = 0; a < RD_LAT; a++) rq[a] = '0;
        repeat (3) @(negedge clk);
        check("R1 busy in reset", int'(busy), 0);
        check("R1 done in reset", int'(done), 0);
        check("R1 rd_en in reset", int'(rd_en), 0);
        check("R1 wr_en in reset", int'(wr_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after reset", int'(busy), 0);
        check("R8 idle strobes after reset", int'(rd_en | wr_en), 0);

        run_case(3, 1'b0);   // directed corners
        run_case(1, 1'b0);   // all negative, most negative first
        run_case(2, 1'b0);   // all non-negative, max and zero
        run_case(0, 1'b1);   // random with stray start (R7)
        for (int k = 0; k < 3; k++) run_case(0, 1'b0);

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule